// File: doc/BRIEF.md
# Packet-Admission FIFO

A single-clock FIFO that moves whole packets between two modules without ever dropping a word by overrun or underrun. Every stored word is widened by two flag bits, one marking the first word of a packet and one marking the last. The writer presents a packet one word per cycle; its first word is held off until the whole packet fits. The reader sees the word at the head of the queue at all times (fall-through), but is offered it only once every word of that packet is already stored. After that, the packet streams through with no stall.

Two admission modes are selected by a static input. In length mode, the packet length is read from the low bits of the header word. In threshold mode, packets have a fixed length, and the two sides are gated by a write threshold and a read threshold on the stored level. On the read side a small checker compares the flags with the expected length. When the flags and the length disagree, it raises a one-cycle error and realigns on the next start flag. A corrupted length field then damages only the packet that carries it.

Top module: `pkt_fifo_gate`

## Requirements
- R1: After reset, rd_level is 0, wr_space equals DEPTH, rd_valid is 0 and rd_err is 0.
- R2: A word is never stored while rd_level equals DEPTH; wr_ready is low for such a word. rd_valid is never high while rd_level is 0.
- R3: In length mode (mode_thr=0), the packet length is wr_data[LEN_W-1:0] of the header word (wr_sop=1), with LEN_W = clog2(MAX_LEN+1). A header with a legal length (1..MAX_LEN) is accepted and stored only when wr_space is at least that length. Otherwise wr_ready stays low and nothing is stored.
- R4: Once a header is stored, every following word up to and including the word with wr_eop=1 is accepted in the cycle it is offered, provided the store is not full.
- R5: In length mode, a header whose length field is 0 or above MAX_LEN is consumed (wr_ready=1) together with every following word up to wr_eop. None of these words is stored.
- R6: A word offered with wr_sop=0 while no packet is open is consumed and discarded.
- R7: In length mode, rd_valid rises on a header only when rd_level is at least the header's length field. The head word is visible on rd_data, rd_sop and rd_eop even while rd_valid is low.
- R8: After a header is taken, each remaining word of that packet is offered with rd_valid high in consecutive cycles, in write order.
- R9: In threshold mode (mode_thr=1), the length field is ignored and every packet is FIX_LEN words long. A header is accepted only while rd_level is at most WR_THR. A header is offered to the reader only while rd_level is at least RD_THR.
- R10: rd_level counts the stored words and wr_space equals DEPTH minus rd_level. A store and a take in the same cycle leave rd_level unchanged.
- R11: If the reader takes the last word the length predicts and that word lacks the end flag, rd_err is high for exactly the following cycle. Stored words are then dropped without being offered until a start flag reaches the head.
- R12: If a taken word carries the end flag before the predicted length, or a start flag reaches the head in mid-packet, rd_err is high for one cycle. In the second case, the word carrying the start flag is offered as the next header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_thr | input | 1 | 0: length-field admission, 1: threshold admission (change only in reset) |
| wr_valid | input | 1 | Write word present |
| wr_sop | input | 1 | Write word is a packet header |
| wr_eop | input | 1 | Write word ends the packet |
| wr_data | input | DW | Write payload; header low LEN_W bits hold the length |
| wr_ready | output | 1 | Write word consumed this cycle |
| wr_space | output | clog2(DEPTH+1) | Free word count |
| rd_valid | output | 1 | Head word may be taken |
| rd_take | input | 1 | Take the head word |
| rd_sop | output | 1 | Head word start flag |
| rd_eop | output | 1 | Head word end flag |
| rd_data | output | DW | Head word payload |
| rd_level | output | clog2(DEPTH+1) | Stored word count |
| rd_err | output | 1 | One-cycle flag/length mismatch pulse |

## Verification
A new header can be admitted in the same cycle as the reader takes a word. Admission is judged against the level before the take, so it must stay conservative, and the level must not move. The bench provokes this by writing a second packet word by word while the first is drained, with both strobes high in the same cycles. It checks that wr_ready is granted, that rd_level stays flat every cycle and that both packets come out intact and in order. The other collision is between the write side filling the last free slot and the read side discarding during resynchronization. The bench drives an over-long packet into a full store and checks that the stall and the realignment resolve to an empty queue with a single error pulse.

// File: rtl/pkt_fifo_pkg.sv
`timescale 1ns/1ps
package pkt_fifo_pkg;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_PASS = 2'd1,
        W_SKIP = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        R_IDLE = 2'd0,
        R_BODY = 2'd1,
        R_DROP = 2'd2
    } rd_state_e;

endpackage

// File: rtl/pkt_fifo_store.sv
`timescale 1ns/1ps
module pkt_fifo_store #(
    parameter int WW    = 18,
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [WW-1:0] push_word,
    input  logic          pop,
    output logic [WW-1:0] front,
    output logic [CW-1:0] level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] lvl;
    } store_t;

    store_t st_d, st_q;
    logic   do_push, do_pop;
    logic [WW-1:0] mem [DEPTH];

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.lvl != CW'(DEPTH));
        do_pop  = pop && (st_q.lvl != '0);
        if (do_push) begin
            st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + AW'(1);
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + AW'(1);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.lvl = st_q.lvl + CW'(1);
            2'b01:   st_d.lvl = st_q.lvl - CW'(1);
            default: st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= push_word;
    end

    assign front = mem[st_q.rp];
    assign level = st_q.lvl;

endmodule

// File: rtl/pkt_fifo_wr_gate.sv
`timescale 1ns/1ps
module pkt_fifo_wr_gate
    import pkt_fifo_pkg::*;
#(
    parameter int DW      = 16,
    parameter int DEPTH   = 16,
    parameter int MAX_LEN = 8,
    parameter int LEN_W   = $clog2(MAX_LEN + 1),
    parameter int WR_THR  = 12,
    parameter int CW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_thr,
    input  logic          wr_valid,
    input  logic          wr_sop,
    input  logic          wr_eop,
    input  logic [DW-1:0] wr_data,
    input  logic [CW-1:0] level,
    output logic          wr_ready,
    output logic          push,
    output logic [DW+1:0] push_word,
    output logic          open
);
    typedef struct packed {
        wr_state_e state;
    } wr_t;

    wr_t st_d, st_q;

    logic [LEN_W-1:0] hdr_len;
    logic [CW-1:0]    space;
    logic             len_ok, room_ok, thr_ok, not_full;

    always_comb begin
        hdr_len  = wr_data[LEN_W-1:0];
        space    = CW'(DEPTH) - level;
        not_full = (level != CW'(DEPTH));
        len_ok   = (hdr_len != '0) && (int'(hdr_len) <= MAX_LEN);
        room_ok  = int'(space) >= int'(hdr_len);
        thr_ok   = (int'(level) <= WR_THR) && not_full;

        st_d     = st_q;
        wr_ready = 1'b0;
        push     = 1'b0;

        case (st_q.state)
            W_IDLE: begin
                if (wr_valid) begin
                    if (!wr_sop) begin
                        wr_ready = 1'b1;
                    end else if (mode_thr) begin
                        wr_ready = thr_ok;
                        push     = thr_ok;
                        if (thr_ok && !wr_eop) st_d.state = W_PASS;
                    end else if (!len_ok) begin
                        wr_ready = 1'b1;
                        if (!wr_eop) st_d.state = W_SKIP;
                    end else begin
                        wr_ready = room_ok;
                        push     = room_ok;
                        if (room_ok && !wr_eop) st_d.state = W_PASS;
                    end
                end
            end
            W_PASS: begin
                wr_ready = not_full;
                push     = wr_valid && not_full;
                if (push && wr_eop) st_d.state = W_IDLE;
            end
            W_SKIP: begin
                wr_ready = 1'b1;
                if (wr_valid && wr_eop) st_d.state = W_IDLE;
            end
            default: st_d.state = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{state: W_IDLE};
        else        st_q <= st_d;
    end

    assign push_word = {wr_sop, wr_eop, wr_data};
    assign open      = (st_q.state == W_PASS);

endmodule

// File: rtl/pkt_fifo_rd_gate.sv
`timescale 1ns/1ps
module pkt_fifo_rd_gate
    import pkt_fifo_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int MAX_LEN = 8,
    parameter int LEN_W   = $clog2(MAX_LEN + 1),
    parameter int RD_THR  = 4,
    parameter int FIX_LEN = 4,
    parameter int CW      = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_thr,
    input  logic             rd_take,
    input  logic             f_sop,
    input  logic             f_eop,
    input  logic [LEN_W-1:0] f_len,
    input  logic [CW-1:0]    level,
    output logic             rd_valid,
    output logic             pop,
    output logic             rd_err,
    output logic             in_pkt
);
    typedef struct packed {
        rd_state_e        state;
        logic [LEN_W-1:0] rem;
        logic             err;
    } rd_t;

    rd_t st_d, st_q;

    logic [LEN_W-1:0] hdr_len, chk_len;
    logic             empty, len_ok, avail, drop, take, last;

    always_comb begin
        empty   = (level == '0);
        hdr_len = mode_thr ? LEN_W'(FIX_LEN) : f_len;
        len_ok  = (f_len != '0) && (int'(f_len) <= MAX_LEN);
        chk_len = (st_q.state == R_IDLE) ? hdr_len : st_q.rem;
        last    = (chk_len == LEN_W'(1));

        st_d     = st_q;
        st_d.err = 1'b0;
        avail    = 1'b0;
        drop     = 1'b0;

        case (st_q.state)
            R_IDLE: begin
                if (!empty) begin
                    if (!f_sop || (!mode_thr && !len_ok)) begin
                        st_d.err   = 1'b1;
                        drop       = 1'b1;
                        st_d.state = R_DROP;
                    end else if (mode_thr) begin
                        avail = int'(level) >= RD_THR;
                    end else begin
                        avail = int'(level) >= int'(f_len);
                    end
                end
            end
            R_BODY: begin
                if (!empty) begin
                    if (f_sop) begin
                        st_d.err   = 1'b1;
                        st_d.state = R_IDLE;
                    end else begin
                        avail = 1'b1;
                    end
                end
            end
            R_DROP: begin
                if (!empty) begin
                    if (f_sop) st_d.state = R_IDLE;
                    else       drop = 1'b1;
                end
            end
            default: st_d.state = R_IDLE;
        endcase

        take = avail && rd_take;
        if (take) begin
            if (last && f_eop) begin
                st_d.state = R_IDLE;
            end else if (last) begin
                st_d.err   = 1'b1;
                st_d.state = R_DROP;
            end else if (f_eop) begin
                st_d.err   = 1'b1;
                st_d.state = R_IDLE;
            end else begin
                st_d.state = R_BODY;
                st_d.rem   = chk_len - LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{state: R_IDLE, rem: '0, err: 1'b0};
        else        st_q <= st_d;
    end

    assign rd_valid = avail;
    assign pop      = take || drop;
    assign rd_err   = st_q.err;
    assign in_pkt   = (st_q.state == R_BODY);

endmodule

// File: rtl/pkt_fifo_gate.sv
`timescale 1ns/1ps
module pkt_fifo_gate #(
    parameter int DW      = 16,
    parameter int DEPTH   = 16,
    parameter int MAX_LEN = 8,
    parameter int FIX_LEN = 4,
    parameter int RD_THR  = 4,
    parameter int WR_THR  = 12,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_thr,
    input  logic          wr_valid,
    input  logic          wr_sop,
    input  logic          wr_eop,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ready,
    output logic [CW-1:0] wr_space,
    output logic          rd_valid,
    input  logic          rd_take,
    output logic          rd_sop,
    output logic          rd_eop,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] rd_level,
    output logic          rd_err
);
    localparam int WW = DW + 2;

    logic          push, pop, wr_open, rd_in_pkt;
    logic [WW-1:0] push_word, front;
    logic [CW-1:0] level;

    pkt_fifo_store #(.WW(WW), .DEPTH(DEPTH), .CW(CW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_word (push_word),
        .pop       (pop),
        .front     (front),
        .level     (level)
    );

    pkt_fifo_wr_gate #(
        .DW(DW), .DEPTH(DEPTH), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W),
        .WR_THR(WR_THR), .CW(CW)
    ) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_thr  (mode_thr),
        .wr_valid  (wr_valid),
        .wr_sop    (wr_sop),
        .wr_eop    (wr_eop),
        .wr_data   (wr_data),
        .level     (level),
        .wr_ready  (wr_ready),
        .push      (push),
        .push_word (push_word),
        .open      (wr_open)
    );

    pkt_fifo_rd_gate #(
        .DEPTH(DEPTH), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W),
        .RD_THR(RD_THR), .FIX_LEN(FIX_LEN), .CW(CW)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_thr (mode_thr),
        .rd_take  (rd_take),
        .f_sop    (front[WW-1]),
        .f_eop    (front[WW-2]),
        .f_len    (front[LEN_W-1:0]),
        .level    (level),
        .rd_valid (rd_valid),
        .pop      (pop),
        .rd_err   (rd_err),
        .in_pkt   (rd_in_pkt)
    );

    assign rd_sop   = front[WW-1];
    assign rd_eop   = front[WW-2];
    assign rd_data  = front[DW-1:0];
    assign rd_level = level;
    assign wr_space = CW'(DEPTH) - level;

endmodule

// File: rtl/pkt_fifo_gate_chk.sv
`timescale 1ns/1ps
module pkt_fifo_gate_chk #(
    parameter int DEPTH   = 16,
    parameter int MAX_LEN = 8,
    parameter int RD_THR  = 4,
    parameter int WR_THR  = 12,
    parameter int LEN_W   = $clog2(MAX_LEN + 1),
    parameter int CW      = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_thr,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic [LEN_W-1:0] wr_len,
    input logic [CW-1:0]    wr_space,
    input logic             rd_valid,
    input logic [LEN_W-1:0] rd_len,
    input logic [CW-1:0]    rd_level,
    input logic             wr_open,
    input logic             rd_in_pkt,
    input logic             push,
    input logic             pop
);
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_level) <= DEPTH);

    a_r2_no_underread: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_level != '0));

    a_r3_room_for_packet: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_thr && !wr_open && push) |-> (int'(wr_space) >= int'(wr_len)));

    a_r4_no_stall_inside: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_open && wr_valid && int'(rd_level) != DEPTH) |-> wr_ready);

    a_r7_whole_packet_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_thr && rd_valid && !rd_in_pkt) |-> (int'(rd_level) >= int'(rd_len)));

    a_r9_write_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_thr && !wr_open && push) |-> (int'(rd_level) <= WR_THR));

    a_r9_read_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_thr && rd_valid && !rd_in_pkt) |-> (int'(rd_level) >= RD_THR));

    a_r10_level_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && int'(rd_level) != DEPTH) |=> (rd_level == $past(rd_level) + CW'(1)));

endmodule

bind pkt_fifo_gate pkt_fifo_gate_chk #(
    .DEPTH(DEPTH), .MAX_LEN(MAX_LEN), .RD_THR(RD_THR), .WR_THR(WR_THR),
    .LEN_W(LEN_W), .CW(CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_thr  (mode_thr),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_len    (wr_data[LEN_W-1:0]),
    .wr_space  (wr_space),
    .rd_valid  (rd_valid),
    .rd_len    (rd_data[LEN_W-1:0]),
    .rd_level  (rd_level),
    .wr_open   (wr_open),
    .rd_in_pkt (rd_in_pkt),
    .push      (push),
    .pop       (pop)
);

// File: tb/sim_pkt_fifo_gate.sv
`timescale 1ns/1ps
module sim_pkt_fifo_gate;
    localparam int DW = 16;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_thr = 1'b0;
    logic        wr_valid = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_ready;
    logic [4:0]  wr_space, rd_level;
    logic        rd_valid, rd_sop, rd_eop, rd_err;
    logic        rd_take = 1'b0;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pkt_fifo_gate u0 (
        .clk(clk), .rst_n(rst_n), .mode_thr(mode_thr),
        .wr_valid(wr_valid), .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_data(wr_data),
        .wr_ready(wr_ready), .wr_space(wr_space),
        .rd_valid(rd_valid), .rd_take(rd_take), .rd_sop(rd_sop), .rd_eop(rd_eop),
        .rd_data(rd_data), .rd_level(rd_level), .rd_err(rd_err)
    );

    function automatic logic [15:0] hdr(input logic [11:0] tag, input logic [3:0] len);
        return {tag, len};
    endfunction

    function automatic logic [15:0] body(input logic [11:0] tag, input int i);
        return {tag, 4'(i)};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic mode);
        rst_n = 1'b0; wr_valid = 1'b0; rd_take = 1'b0; mode_thr = mode;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic put_word(input logic s, input logic e, input logic [15:0] d);
        int n = 0;
        wr_valid = 1'b1; wr_sop = s; wr_eop = e; wr_data = d;
        #1;
        while (!wr_ready && n < 200) begin
            tick(); #1; n++;
        end
        if (n >= 200) chk("R4", "write accept timeout", 0, 1);
        @(posedge clk); @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic put_pkt(input logic [11:0] tag, input logic [3:0] len, input int nw, input int eop_at);
        for (int i = 0; i < nw; i++)
            put_word(i == 0, i == eop_at - 1, (i == 0) ? hdr(tag, len) : body(tag, i));
    endtask

    task automatic peek_hdr(input logic [3:0] len, input int exp, input string req);
        wr_valid = 1'b1; wr_sop = 1'b1; wr_eop = 1'b0; wr_data = hdr(12'hABC, len);
        #1;
        chk(req, "header wr_ready", int'(wr_ready), exp);
        wr_valid = 1'b0;
        tick();
    endtask

    task automatic take(input logic [15:0] d, input logic s, input logic e, input string req);
        chk(req, "rd_valid", int'(rd_valid), 1);
        chk(req, "rd_data", int'(rd_data), int'(d));
        chk(req, "rd_sop/eop", int'({rd_sop, rd_eop}), int'({s, e}));
        rd_take = 1'b1;
        tick();
        rd_take = 1'b0;
    endtask

    initial begin
        #3000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset(1'b0);
        chk("R1", "rd_level", int'(rd_level), 0);
        chk("R1", "wr_space", int'(wr_space), DEPTH);
        chk("R1", "rd_valid", int'(rd_valid), 0);
        chk("R1", "rd_err", int'(rd_err), 0);

        // R6 stray word while idle
        wr_valid = 1'b1; wr_sop = 1'b0; wr_eop = 1'b0; wr_data = 16'h1234;
        #1 chk("R6", "stray wr_ready", int'(wr_ready), 1);
        tick(); wr_valid = 1'b0;
        chk("R6", "level after stray", int'(rd_level), 0);

        // R5 illegal length fields
        put_pkt(12'h001, 4'd0, 3, 3);
        chk("R5", "level after len 0", int'(rd_level), 0);
        put_pkt(12'h002, 4'd9, 2, 2);
        chk("R5", "level after len 9", int'(rd_level), 0);

        // R7 fall-through head and read admission, R8 streaming
        put_word(1'b1, 1'b0, hdr(12'h003, 4'd5));
        put_word(1'b0, 1'b0, body(12'h003, 1));
        put_word(1'b0, 1'b0, body(12'h003, 2));
        chk("R7", "partial level", int'(rd_level), 3);
        chk("R7", "head sop visible", int'(rd_sop), 1);
        chk("R7", "head data visible", int'(rd_data), int'(hdr(12'h003, 4'd5)));
        chk("R7", "rd_valid held", int'(rd_valid), 0);
        put_word(1'b0, 1'b0, body(12'h003, 3));
        chk("R7", "rd_valid at 4 of 5", int'(rd_valid), 0);
        put_word(1'b0, 1'b1, body(12'h003, 4));
        chk("R10", "level 5", int'(rd_level), 5);
        chk("R10", "space 11", int'(wr_space), 11);
        take(hdr(12'h003, 4'd5), 1'b1, 1'b0, "R7");
        for (int i = 1; i < 5; i++) begin
            take(body(12'h003, i), 1'b0, i == 4, "R8");
            chk("R10", "level drains", int'(rd_level), 4 - i);
        end
        chk("R8", "rd_err clean", int'(rd_err), 0);

        // R3 admission sweep over level and length
        do_reset(1'b0);
        for (int f = 0; f <= 4; f++) begin
            for (int n = 1; n <= 8; n++)
                peek_hdr(4'(n), (DEPTH - 4 * f >= n) ? 1 : 0, "R3");
            chk("R3", "level unchanged by refusals", int'(rd_level), 4 * f);
            if (f < 4) put_pkt(12'h010 + 12'(f), 4'd4, 4, 4);
        end

        // R2 full guard, R11 length overrun and resync
        do_reset(1'b0);
        put_word(1'b1, 1'b0, hdr(12'h005, 4'd2));
        for (int i = 1; i < 16; i++) put_word(1'b0, 1'b0, body(12'h005, i));
        chk("R2", "level full", int'(rd_level), 16);
        wr_valid = 1'b1; wr_sop = 1'b0; wr_eop = 1'b0; wr_data = 16'hEEEE;
        #1 chk("R2", "wr_ready when full", int'(wr_ready), 0);
        wr_valid = 1'b0;
        tick();
        chk("R2", "level still full", int'(rd_level), 16);
        take(hdr(12'h005, 4'd2), 1'b1, 1'b0, "R11");
        take(body(12'h005, 1), 1'b0, 1'b0, "R11");
        chk("R11", "rd_err pulse", int'(rd_err), 1);
        chk("R11", "no offer during drop", int'(rd_valid), 0);
        chk("R11", "level at drop start", int'(rd_level), 14);
        for (int i = 0; i < 14; i++) tick();
        chk("R11", "dropped to empty", int'(rd_level), 0);
        chk("R11", "rd_err one cycle", int'(rd_err), 0);
        put_word(1'b0, 1'b1, body(12'h005, 0));
        tick();
        chk("R11", "tail dropped", int'(rd_level), 0);
        put_pkt(12'h006, 4'd2, 2, 2);
        take(hdr(12'h006, 4'd2), 1'b1, 1'b0, "R11");
        take(body(12'h006, 1), 1'b0, 1'b1, "R11");

        // R12 early end flag
        do_reset(1'b0);
        put_pkt(12'h006, 4'd4, 2, 2);
        put_pkt(12'h007, 4'd3, 3, 3);
        chk("R12", "level 5", int'(rd_level), 5);
        take(hdr(12'h006, 4'd4), 1'b1, 1'b0, "R12");
        take(body(12'h006, 1), 1'b0, 1'b1, "R12");
        chk("R12", "rd_err early eop", int'(rd_err), 1);
        take(hdr(12'h007, 4'd3), 1'b1, 1'b0, "R12");
        chk("R12", "rd_err clears", int'(rd_err), 0);
        take(body(12'h007, 1), 1'b0, 1'b0, "R12");
        take(body(12'h007, 2), 1'b0, 1'b1, "R12");

        // R12 start flag inside a packet
        do_reset(1'b0);
        put_word(1'b1, 1'b0, hdr(12'h008, 4'd4));
        put_word(1'b0, 1'b0, body(12'h008, 1));
        put_word(1'b1, 1'b0, hdr(12'h009, 4'd2));
        put_word(1'b0, 1'b1, body(12'h009, 1));
        take(hdr(12'h008, 4'd4), 1'b1, 1'b0, "R12");
        take(body(12'h008, 1), 1'b0, 1'b0, "R12");
        chk("R12", "mid sop withheld", int'(rd_valid), 0);
        chk("R12", "rd_err not yet", int'(rd_err), 0);
        tick();
        chk("R12", "rd_err mid sop", int'(rd_err), 1);
        take(hdr(12'h009, 4'd2), 1'b1, 1'b0, "R12");
        take(body(12'h009, 1), 1'b0, 1'b1, "R12");
        chk("R12", "empty after", int'(rd_level), 0);

        // R10 simultaneous store and take
        do_reset(1'b0);
        put_pkt(12'h011, 4'd8, 8, 8);
        for (int i = 0; i < 4; i++) begin
            wr_valid = 1'b1; wr_sop = (i == 0); wr_eop = (i == 3);
            wr_data = (i == 0) ? hdr(12'h012, 4'd4) : body(12'h012, i);
            rd_take = 1'b1;
            #1;
            chk("R10", "concurrent wr_ready", int'(wr_ready), 1);
            chk("R10", "concurrent rd_valid", int'(rd_valid), 1);
            chk("R10", "concurrent rd_data", int'(rd_data),
                int'((i == 0) ? hdr(12'h011, 4'd8) : body(12'h011, i)));
            tick();
            chk("R10", "level flat", int'(rd_level), 8);
        end
        wr_valid = 1'b0; rd_take = 1'b0;
        for (int i = 4; i < 8; i++) take(body(12'h011, i), 1'b0, i == 7, "R10");
        take(hdr(12'h012, 4'd4), 1'b1, 1'b0, "R10");
        for (int i = 1; i < 4; i++) take(body(12'h012, i), 1'b0, i == 3, "R10");
        chk("R10", "empty", int'(rd_level), 0);

        // R9 threshold mode
        do_reset(1'b1);
        put_word(1'b1, 1'b0, hdr(12'h013, 4'd0));
        put_word(1'b0, 1'b0, body(12'h013, 1));
        put_word(1'b0, 1'b0, body(12'h013, 2));
        chk("R9", "len field ignored", int'(rd_level), 3);
        chk("R9", "below read threshold", int'(rd_valid), 0);
        put_word(1'b0, 1'b1, body(12'h013, 3));
        chk("R9", "at read threshold", int'(rd_valid), 1);
        for (int f = 1; f <= 3; f++) begin
            peek_hdr(4'd15, 1, "R9");
            put_pkt(12'h020 + 12'(f), 4'd15, 4, 4);
        end
        chk("R9", "level 16", int'(rd_level), 16);
        peek_hdr(4'd1, 0, "R9");
        take(hdr(12'h013, 4'd0), 1'b1, 1'b0, "R9");
        for (int i = 1; i < 4; i++) take(body(12'h013, i), 1'b0, i == 3, "R9");
        chk("R9", "no error at fixed length", int'(rd_err), 0);
        peek_hdr(4'd1, 1, "R9");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule